// File: doc/BRIEF.md
# Calibrated DDR Read-Valid Aligner

A DDR2 SDRAM returns read data with no strobe that says when the data is valid. This block makes that strobe. It generates one. When the controller issues a read command, the block waits for the CAS latency and then raises an enable pulse. The pulse lasts as many divided-clock cycles as the burst needs, given how many data words the deserializer delivers per divided-clock cycle.

The enable pulse then feeds one delay line for each byte lane. Each delay line is a 16-stage shift register with a selectable tap. A calibration step outside this block sets the tap depth for each lane through a run-time input. The tapped bit is registered again on a copy of the divided clock shifted by a quarter period. This places the strobe in the same timing window as the deserialized read data of that lane.

The block leaves out the search that picks the tap depths, the deserializers and the memory PHY.

Top module: `ddr_rdvalid_align`

## Requirements
- R1: A synchronous active-high reset clears the command pipeline, the burst counter, every delay stage and every output flop. `rd_valid` reads 0 during reset, and a read that is in flight when reset is asserted never appears on the output.
- R2: A read command is sampled on a rising edge E of `clk_div`. For a lane with stage count S and CAS latency CL, that lane's `rd_valid` first goes high right after the `clk_div90` rising edge that follows `clk_div` edge E+CL+S+1.
- R3: Each read gives a valid window of BURST_LEN/WORDS_PER_CYC divided-clock cycles. With the defaults (burst 8, 4 words per cycle) this is 2 cycles.
- R4: Read commands spaced exactly BURST_LEN/WORDS_PER_CYC cycles apart give one unbroken valid window, with no gap between the bursts. Commands closer together than that are not supported.
- R5: Each lane's stage count is a 4-bit field with values 0 to 15. Every increment of the count adds one divided-clock cycle of delay.
- R6: Lane n takes its stage count from bits [4n+3:4n] of `lane_stage` and drives `rd_valid[n]`. Lanes with different counts delay the same pulse independently of each other.
- R7: `rd_valid` changes only at rising edges of `clk_div90`. In the quarter period after a `clk_div` edge and before the next `clk_div90` edge, the output holds its previous value.
- R8: A change of a lane's stage count is used at the next `clk_div90` capture. Bits already in the delay line are not flushed, so the output then shows the line bit at the new tap position.
- R9: `cas_lat` must be in the range 3 to 5 whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Divided clock; drives the command pipeline, burst counter and delay lines |
| clk_div90 | input | 1 | Divided clock shifted by 90 degrees; drives the output flops |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| rd_cmd | input | 1 | Read command accepted, one cycle per burst |
| cas_lat | input | 3 | CAS latency in divided-clock cycles (3 to 5) |
| lane_stage | input | LANES*4 | Packed per-lane stage counts, lane 0 in the low nibble |
| rd_valid | output | LANES | Per-lane read-data-valid strobe |

## Verification
Two events can fall in the same cycle. The first is a new read command reloading the burst counter. The second is the counter finishing the previous burst, or a lane's tap moving while a pulse is still in its delay line. To provoke the first case, the bench issues reads exactly one burst apart and checks that the valid window is one unbroken run of three bursts. To provoke the second case, it changes the stage counts of both lanes while a pulse is travelling. It then compares every cycle of the output with a bench-side model, which indexes the history of the generated pulse with the tap value that was applied in the previous cycle.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

   localparam int unsigned RDV_CL_W    = 3;
   localparam int unsigned RDV_STAGE_W = 4;
   localparam int unsigned RDV_TAPS_HW = 1 << RDV_STAGE_W;

   typedef logic [RDV_CL_W-1:0]    rdv_cl_t;
   typedef logic [RDV_STAGE_W-1:0] rdv_stage_t;

endpackage

// File: rtl/rdv_pulse_gen.sv
module rdv_pulse_gen
   import rdv_pkg::*;
#(
   parameter int unsigned CL_MIN = 3,
   parameter int unsigned CL_MAX = 5,
   parameter int unsigned BEATS  = 2
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    rd_cmd,
   input  rdv_cl_t cas_lat,
   output logic    gen_en
);

   localparam int unsigned RW = (BEATS < 2) ? 1 : $clog2(BEATS + 1);

   logic [CL_MAX:1] cmd_pipe;
   logic            launch;

   always_ff @(posedge clk) begin
      if (rst) cmd_pipe <= '0;
      else     cmd_pipe <= {cmd_pipe[CL_MAX-1:1], rd_cmd};
   end

   always_comb begin
      launch = 1'b0;
      for (int i = CL_MIN; i <= CL_MAX; i++) begin
         if (cas_lat == rdv_cl_t'(i)) launch = cmd_pipe[i];
      end
   end

   generate
      if (BEATS == 1) begin : g_single
         logic en_q;
         always_ff @(posedge clk) begin
            if (rst) en_q <= 1'b0;
            else     en_q <= launch;
         end
         assign gen_en = en_q;
      end else begin : g_multi
         logic [RW-1:0] rem;
         always_ff @(posedge clk) begin
            if (rst)             rem <= '0;
            else if (launch)     rem <= RW'(BEATS);
            else if (rem != '0)  rem <= rem - 1'b1;
         end
         assign gen_en = (rem != '0);
      end
   endgenerate

   // run length of the generated pulse, used by the burst assertion
   logic [7:0] run_len;
   always_ff @(posedge clk) begin
      if (rst)         run_len <= '0;
      else if (gen_en) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   AST_CAS_RANGE: assert property (@(posedge clk) disable iff (rst)
      (cas_lat >= rdv_cl_t'(CL_MIN)) && (cas_lat <= rdv_cl_t'(CL_MAX))); // R9

   AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (rst)
      launch |=> gen_en); // R2

   AST_BURST_MULT: assert property (@(posedge clk) disable iff (rst)
      (!gen_en && run_len != '0) |-> ((run_len % BEATS) == 0)); // R3

endmodule

// File: rtl/rdv_delay_lane.sv
module rdv_delay_lane
   import rdv_pkg::*;
#(
   parameter int unsigned TAPS = 16
) (
   input  logic       clk,
   input  logic       clk90,
   input  logic       rst,
   input  logic       en_in,
   input  rdv_stage_t stage,
   output logic       valid
);

   logic [TAPS-1:0] srl;
   logic            tap;
   logic            valid_q;

   always_ff @(posedge clk) begin
      if (rst) srl <= '0;
      else     srl <= {srl[TAPS-2:0], en_in};
   end

   generate
      if (TAPS == RDV_TAPS_HW) begin : g_full
         assign tap = srl[stage];
      end else begin : g_part
         assign tap = (int'(stage) < TAPS) ? srl[stage] : srl[TAPS-1];
      end
   endgenerate

   always_ff @(posedge clk90) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= tap;
   end

   assign valid = valid_q;

   AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (srl == '0)); // R1

   AST_OUT_CLEARED: assert property (@(posedge clk90) disable iff (rst)
      $fell(rst) |-> !valid_q); // R1

endmodule

// File: rtl/ddr_rdvalid_align.sv
module ddr_rdvalid_align
   import rdv_pkg::*;
#(
   parameter int unsigned LANES         = 2,
   parameter int unsigned TAPS          = 16,
   parameter int unsigned BURST_LEN     = 8,
   parameter int unsigned WORDS_PER_CYC = 4,
   parameter int unsigned CL_MIN        = 3,
   parameter int unsigned CL_MAX        = 5
) (
   input  logic                         clk_div,
   input  logic                         clk_div90,
   input  logic                         rst,
   input  logic                         rd_cmd,
   input  logic [RDV_CL_W-1:0]          cas_lat,
   input  logic [LANES*RDV_STAGE_W-1:0] lane_stage,
   output logic [LANES-1:0]             rd_valid
);

   localparam int unsigned BEATS = BURST_LEN / WORDS_PER_CYC;

   generate
      if (TAPS < 2 || TAPS > RDV_TAPS_HW) begin : g_bad_taps
         $error("TAPS out of range");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (BEATS < 1 || (BURST_LEN % WORDS_PER_CYC) != 0) begin : g_bad_burst
         $error("BURST_LEN must be a multiple of WORDS_PER_CYC");
      end
      if (CL_MIN < 1 || CL_MAX < 2 || CL_MIN > CL_MAX || CL_MAX >= (1 << RDV_CL_W)) begin : g_bad_cl
         $error("CAS latency range invalid");
      end
   endgenerate

   logic gen_en;

   rdv_pulse_gen #(
      .CL_MIN (CL_MIN),
      .CL_MAX (CL_MAX),
      .BEATS  (BEATS)
   ) u_gen (
      .clk     (clk_div),
      .rst     (rst),
      .rd_cmd  (rd_cmd),
      .cas_lat (rdv_cl_t'(cas_lat)),
      .gen_en  (gen_en)
   );

   generate
      for (genvar n = 0; n < LANES; n++) begin : g_lane
         rdv_delay_lane #(
            .TAPS (TAPS)
         ) u_lane (
            .clk   (clk_div),
            .clk90 (clk_div90),
            .rst   (rst),
            .en_in (gen_en),
            .stage (rdv_stage_t'(lane_stage[n*RDV_STAGE_W +: RDV_STAGE_W])),
            .valid (rd_valid[n])
         );
      end
   endgenerate

endmodule

// File: tb/ddr_rdvalid_align_bench.sv
`timescale 1ns/1ps
module ddr_rdvalid_align_bench;

   localparam int BEATS = 2;

   logic       clk_div = 1'b0;
   logic       clk_div90;
   logic       rst = 1'b1;
   logic       rd_cmd = 1'b0;
   logic [2:0] cas_lat = 3'd3;
   logic [7:0] lane_stage = 8'h00;
   logic [1:0] rd_valid;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk_div = ~clk_div;
   assign #1.25 clk_div90 = clk_div;

   ddr_rdvalid_align u_ddr_rdvalid_align (
      .clk_div    (clk_div),
      .clk_div90  (clk_div90),
      .rst        (rst),
      .rd_cmd     (rd_cmd),
      .cas_lat    (cas_lat),
      .lane_stage (lane_stage),
      .rd_valid   (rd_valid)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // generated pulse value after clk edge idx (bench model of R2/R3)
   function automatic bit gexp(input logic [63:0] pat, input int cas, input int idx);
      for (int k = 0; k <= idx && k < 64; k++) begin
         if (pat[k] && (idx - k - cas) >= 0 && (idx - k - cas) < BEATS) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic run_case(input string req, input logic [63:0] pat, input int cas,
                           input int s0a, input int s0b, input int s1a, input int s1b,
                           input int sw, output int run0);
      int st0[64];
      int st1[64];
      int bad_cyc[2];
      int bad_act[2];
      int bad_exp[2];
      int phase_bad;
      int run;
      logic [1:0] obs;
      for (int m = 0; m < 64; m++) begin
         st0[m] = (m < sw) ? s0a : s0b;
         st1[m] = (m < sw) ? s1a : s1b;
      end
      bad_cyc[0] = -1; bad_cyc[1] = -1;
      bad_act[0] = 0; bad_act[1] = 0; bad_exp[0] = 0; bad_exp[1] = 0;
      phase_bad = -1; run = 0; run0 = 0;
      cas_lat = 3'(cas);
      for (int m = 0; m < 64; m++) begin
         @(negedge clk_div);
         obs = rd_valid;
         for (int l = 0; l < 2; l++) begin
            bit e;
            int st;
            e = 1'b0;
            if (m >= 1) begin
               st = (l == 0) ? st0[m-1] : st1[m-1];
               if (m - 2 - st >= 0) e = gexp(pat, cas, m - 2 - st);
            end
            if (obs[l] !== e && bad_cyc[l] < 0) begin
               bad_cyc[l] = m; bad_act[l] = int'(obs[l]); bad_exp[l] = int'(e);
            end
         end
         if (obs[0] === 1'b1) begin
            run++;
            if (run > run0) run0 = run;
         end else begin
            run = 0;
         end
         rd_cmd = pat[m];
         lane_stage = {4'(st1[m]), 4'(st0[m])};
         @(posedge clk_div);
         #0.5;
         if (rd_valid !== obs && phase_bad < 0) phase_bad = m;
      end
      @(negedge clk_div);
      rd_cmd = 1'b0;
      for (int l = 0; l < 2; l++) begin
         check(bad_cyc[l] < 0, req, $sformatf("lane%0d mismatch at cycle %0d", l, bad_cyc[l]),
               bad_act[l], bad_exp[l]);
      end
      check(phase_bad < 0, "R7", $sformatf("output moved before quarter-phase edge, cycle %0d", phase_bad),
            phase_bad, -1);
   endtask

   task automatic t_reset_state;
      @(negedge clk_div);
      check(rd_valid === 2'b00, "R1", "rd_valid during reset", int'(rd_valid), 0);
      repeat (3) @(negedge clk_div);
      rst = 1'b0;
      @(negedge clk_div);
      check(rd_valid === 2'b00, "R1", "rd_valid after reset release", int'(rd_valid), 0);
   endtask

   task automatic t_single_min;
      int r;
      run_case("R2", 64'h1, 3, 0, 0, 0, 0, 64, r);
      check(r == BEATS, "R3", "window length, single read", r, BEATS);
   endtask

   task automatic t_max_stage;
      int r;
      run_case("R5", 64'h1, 5, 15, 15, 7, 7, 64, r);
      check(r == BEATS, "R3", "window length at stage 15", r, BEATS);
   endtask

   task automatic t_lanes_apart;
      int r;
      run_case("R6", 64'h41, 4, 3, 3, 9, 9, 64, r);
   endtask

   task automatic t_back_to_back;
      int r;
      run_case("R4", 64'h15, 3, 1, 1, 4, 4, 64, r);
      check(r == 3 * BEATS, "R4", "unbroken run for three back-to-back reads", r, 3 * BEATS);
   endtask

   task automatic t_stage_switch;
      int r;
      run_case("R8", 64'h1, 3, 2, 10, 10, 2, 5, r);
      run_case("R8", 64'h1, 4, 0, 6, 6, 0, 6, r);
   endtask

   task automatic t_reset_midflight;
      int seen;
      seen = 0;
      @(negedge clk_div);
      cas_lat = 3'd3;
      lane_stage = 8'h55;
      rd_cmd = 1'b1;
      @(negedge clk_div);
      rd_cmd = 1'b0;
      repeat (5) @(negedge clk_div);
      rst = 1'b1;
      repeat (2) @(negedge clk_div);
      rst = 1'b0;
      for (int m = 0; m < 30; m++) begin
         @(negedge clk_div);
         if (rd_valid !== 2'b00) seen++;
      end
      check(seen == 0, "R1", "cycles with valid after reset hit in-flight read", seen, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_single_min();
      t_max_stage();
      t_lanes_apart();
      t_back_to_back();
      t_stage_switch();
      t_reset_midflight();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule